// File: doc/BRIEF.md
# Multi-Mode PWM Channel Core

This block is one pulse-width-modulation channel: a time base counter and an output compare stage. Three values control it: the period, the duty and the phase. Each value has two sources, the channel's own input and a shared master input, and a separate select bit picks the source for each value. A mode field chooses the counting scheme. The edge-aligned modes count up and wrap. The center-aligned modes count up, then down.

The counter advances on a clock-enable strobe. A clock-select field picks that strobe: none, every clock, an external divider tick or an external scaling tick. An enable bit starts the channel. Mode and clock-select writes are refused while the channel runs. A freeze bit lets a debug-halt input stop the counter.

The channel drives the PWM level, a one-clock end-of-cycle pulse and an update strobe. The update strobe marks each point where the channel loads new period, duty and phase values into its working copies.

Top module: `pwm_chan_core`

## Requirements
- R1: Select bits pick the source of each value independently: cfg_src_per for the period, cfg_src_duty for the duty and cfg_src_ph for the phase. A 1 picks the master input (mst_*) and a 0 picks the channel input (loc_*).
- R2: The edge modes are 3'b000 (plain edge), 3'b001 (shifted phase) and 3'b010 (edge, second output slot). In these modes the counter steps 0..P, so a cycle lasts P+1 ticks. pwm_o is high while PH <= count < PH+D, which gives D high ticks when PH+D <= P+1.
- R3: The center modes are 3'b100, 3'b101, 3'b110 and 3'b111. In these modes the counter climbs 0..P-1 and then falls P-1..0, holding each end value for one extra tick. A cycle lasts 2P ticks. pwm_o is high while count < D, which gives 2D high ticks when D <= P.
- R4: eoc_o pulses for one clock at the start of each cycle. upd_o pulses whenever working values load during a run: once per cycle, plus once more at the top in modes 3'b101 and 3'b111.
- R5: cfg_clk selects the tick: 2'b00 gives no tick (the counter does not advance), 2'b01 ticks every clock, 2'b10 ticks on div_tick and 2'b11 ticks on scale_tick. Duty and period stretch by the same factor.
- R6: If the channel is already enabled when a configuration write arrives, the write leaves cfg_mode and cfg_clk unchanged. The other fields of that write still take effect.
- R7: With the freeze bit set, the counter holds while dbg_halt is high. With the freeze bit clear, dbg_halt has no effect.
- R8: All configuration fields reset to 0. While the channel is disabled, the counter rests at 0, pwm_o is low and no strobes are produced.
- R9: The reserved mode 3'b011 keeps the counter idle, pwm_o low and both strobes silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Channel enable |
| cfg_frz | input | 1 | Freeze on debug halt |
| cfg_clk | input | 2 | Tick source select |
| cfg_mode | input | 3 | Counting mode |
| cfg_src_per | input | 1 | Period source (1 = master) |
| cfg_src_duty | input | 1 | Duty source (1 = master) |
| cfg_src_ph | input | 1 | Phase source (1 = master) |
| loc_per | input | CNT_W | Channel period |
| loc_duty | input | CNT_W | Channel duty |
| loc_ph | input | CNT_W | Channel phase |
| mst_per | input | CNT_W | Master period |
| mst_duty | input | CNT_W | Master duty |
| mst_ph | input | CNT_W | Master phase |
| div_tick | input | 1 | Divided-clock enable strobe |
| scale_tick | input | 1 | Scaled-clock enable strobe |
| dbg_halt | input | 1 | Debug halt request |
| pwm_o | output | 1 | PWM level |
| eoc_o | output | 1 | End-of-cycle pulse |
| upd_o | output | 1 | Working-value update strobe |

## Verification
The assertions assume that configuration fields change only through cfg_we. They also assume that a center mode is never run with a period of 0, and that div_tick and scale_tick are single-clock strobes. The bench keeps within these limits. It drives the tick strobes from a free-running counter at fixed ratios, uses periods of at least 5 and duties that fit inside the period, and clears the enable before it loads a new mode or tick source. The lock and freeze cases are the only ones that write while the channel runs.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic [2:0] {
    MD_EDGE     = 3'b000,
    MD_SHIFT    = 3'b001,
    MD_EDGE2    = 3'b010,
    MD_RSVD     = 3'b011,
    MD_CTR      = 3'b100,
    MD_CTR_DUP  = 3'b101,
    MD_DCTR_ONE = 3'b110,
    MD_DCTR_TWO = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_FULL  = 2'b01,
    TK_DIV   = 2'b10,
    TK_SCALE = 2'b11
  } tick_e;

  typedef struct packed {
    logic       en;
    logic       frz;
    logic [2:0] src;   // [0] period, [1] duty, [2] phase
    mode_e      mode;
    tick_e      tck;
  } cfg_t;

  function automatic logic is_center(mode_e m);
    return m[2];
  endfunction

  function automatic logic is_dual_upd(mode_e m);
    return (m == MD_CTR_DUP) || (m == MD_DCTR_TWO);
  endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  cfg_t wdata,
  output cfg_t cfg_q
);

  cfg_t cfg_n;

  always_comb begin
    cfg_n = cfg_q;
    if (we) begin
      cfg_n.en  = wdata.en;
      cfg_n.frz = wdata.frz;
      cfg_n.src = wdata.src;
      if (!cfg_q.en) begin
        cfg_n.mode = wdata.mode;
        cfg_n.tck  = wdata.tck;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  AST_LOCK_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && we) |=> (cfg_q.mode == $past(cfg_q.mode)) && (cfg_q.tck == $past(cfg_q.tck))); // R6

endmodule

// File: rtl/pwm_src_sel.sv
module pwm_src_sel #(
  parameter int CNT_W = 16,
  parameter int NVAL  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NVAL-1:0]            src,
  input  logic [NVAL-1:0][CNT_W-1:0] loc_v,
  input  logic [NVAL-1:0][CNT_W-1:0] mst_v,
  output logic [NVAL-1:0][CNT_W-1:0] act_v
);

  for (genvar g = 0; g < NVAL; g++) begin : g_val
    logic [CNT_W-1:0] pick;
    logic [CNT_W-1:0] act_n;

    always_comb begin
      pick  = src[g] ? mst_v[g] : loc_v[g];
      act_n = load ? pick : act_v[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_v[g] <= '0;
      else        act_v[g] <= act_n;
    end

    AST_SRC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> act_v[g] == ($past(src[g]) ? $past(mst_v[g]) : $past(loc_v[g]))); // R1
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frz,
  input  logic             dbg_halt,
  input  mode_e            mode,
  input  tick_e            tck,
  input  logic             div_tick,
  input  logic             scale_tick,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             mid,
  output logic             eoc_q,
  output logic             upd_q
);

  logic             down_q, down_n;
  logic [CNT_W-1:0] cnt_n, top;
  logic             tick, step, center;

  always_comb begin
    unique case (tck)
      TK_FULL:  tick = 1'b1;
      TK_DIV:   tick = div_tick;
      TK_SCALE: tick = scale_tick;
      default:  tick = 1'b0;
    endcase
    center = is_center(mode);
    step   = en && tick && !(frz && dbg_halt) && (mode != MD_RSVD);
    top    = (per == '0) ? '0 : per - 1'b1;
    cnt_n  = cnt_q;
    down_n = down_q;
    wrap   = 1'b0;
    mid    = 1'b0;
    if (!en) begin
      cnt_n  = '0;
      down_n = 1'b0;
    end else if (step) begin
      if (!center) begin
        if (cnt_q >= per) begin
          cnt_n = '0;
          wrap  = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else if (!down_q) begin
        if (cnt_q >= top) begin
          down_n = 1'b1;
          mid    = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          down_n = 1'b0;
          wrap   = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      eoc_q  <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
      eoc_q  <= wrap;
      upd_q  <= wrap || (mid && is_dual_upd(mode));
    end
  end

  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !center && mode != MD_RSVD) |-> cnt_q <= per); // R2
  AST_EOC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_q |-> cnt_q == '0); // R4
  AST_MID_DUAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !eoc_q) |-> is_dual_upd(mode)); // R4
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tck == TK_NONE) |=> $stable(cnt_q)); // R5
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frz && dbg_halt) |=> $stable(cnt_q)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0) && !eoc_q); // R8
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MD_RSVD) |=> !eoc_q && !upd_q); // R9

endmodule

// File: rtl/pwm_out_cmp.sv
module pwm_out_cmp
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             en,
  input  mode_e            mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] ph,
  output logic             pwm
);

  logic [CNT_W:0] stop_at;
  logic           hit;

  always_comb begin
    stop_at = {1'b0, ph} + {1'b0, duty};
    if (is_center(mode)) hit = cnt < duty;
    else                 hit = (cnt >= ph) && ({1'b0, cnt} < stop_at);
    pwm = en && (mode != MD_RSVD) && hit;
  end

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic             cfg_frz,
  input  logic [1:0]       cfg_clk,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_src_per,
  input  logic             cfg_src_duty,
  input  logic             cfg_src_ph,
  input  logic [CNT_W-1:0] loc_per,
  input  logic [CNT_W-1:0] loc_duty,
  input  logic [CNT_W-1:0] loc_ph,
  input  logic [CNT_W-1:0] mst_per,
  input  logic [CNT_W-1:0] mst_duty,
  input  logic [CNT_W-1:0] mst_ph,
  input  logic             div_tick,
  input  logic             scale_tick,
  input  logic             dbg_halt,
  output logic             pwm_o,
  output logic             eoc_o,
  output logic             upd_o
);

  localparam int NVAL = 3;
  localparam int IX_PER = 0;
  localparam int IX_DUTY = 1;
  localparam int IX_PH = 2;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  cfg_t wdata, cfg_q;
  always_comb begin
    wdata.en   = cfg_en;
    wdata.frz  = cfg_frz;
    wdata.src  = {cfg_src_ph, cfg_src_duty, cfg_src_per};
    wdata.mode = mode_e'(cfg_mode);
    wdata.tck  = tick_e'(cfg_clk);
  end

  pwm_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_ni), .we(cfg_we), .wdata(wdata), .cfg_q(cfg_q)
  );

  logic [NVAL-1:0][CNT_W-1:0] loc_v, mst_v, act_v;
  logic [CNT_W-1:0]           cnt;
  logic                       wrap, mid, load;

  assign loc_v = {loc_ph, loc_duty, loc_per};
  assign mst_v = {mst_ph, mst_duty, mst_per};
  assign load  = !cfg_q.en || wrap || (mid && is_dual_upd(cfg_q.mode));

  pwm_src_sel #(.CNT_W(CNT_W), .NVAL(NVAL)) u_src (
    .clk(clk), .rst_n(rst_ni), .load(load), .src(cfg_q.src),
    .loc_v(loc_v), .mst_v(mst_v), .act_v(act_v)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_ni), .en(cfg_q.en), .frz(cfg_q.frz),
    .dbg_halt(dbg_halt), .mode(cfg_q.mode), .tck(cfg_q.tck),
    .div_tick(div_tick), .scale_tick(scale_tick), .per(act_v[IX_PER]),
    .cnt_q(cnt), .wrap(wrap), .mid(mid), .eoc_q(eoc_o), .upd_q(upd_o)
  );

  pwm_out_cmp #(.CNT_W(CNT_W)) u_cmp (
    .en(cfg_q.en), .mode(cfg_q.mode), .cnt(cnt),
    .duty(act_v[IX_DUTY]), .ph(act_v[IX_PH]), .pwm(pwm_o)
  );

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg_q.en |-> !pwm_o && !upd_o); // R8

endmodule

// File: tb/pwm_chan_core_tb_top.sv
module pwm_chan_core_tb_top;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_en, cfg_frz, cfg_src_per, cfg_src_duty, cfg_src_ph;
  logic [1:0] cfg_clk;
  logic [2:0] cfg_mode;
  logic [W-1:0] loc_per, loc_duty, loc_ph, mst_per, mst_duty, mst_ph;
  logic div_tick, scale_tick, dbg_halt;
  logic pwm_o, eoc_o, upd_o;

  always #2 clk = ~clk;

  pwm_chan_core #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_frz(cfg_frz), .cfg_clk(cfg_clk), .cfg_mode(cfg_mode),
    .cfg_src_per(cfg_src_per), .cfg_src_duty(cfg_src_duty),
    .cfg_src_ph(cfg_src_ph), .loc_per(loc_per), .loc_duty(loc_duty),
    .loc_ph(loc_ph), .mst_per(mst_per), .mst_duty(mst_duty),
    .mst_ph(mst_ph), .div_tick(div_tick), .scale_tick(scale_tick),
    .dbg_halt(dbg_halt), .pwm_o(pwm_o), .eoc_o(eoc_o), .upd_o(upd_o)
  );

  int tcnt = 0;
  always @(negedge clk) begin
    div_tick   <= (tcnt % 2) == 0;
    scale_tick <= (tcnt % 3) == 0;
    tcnt       <= tcnt + 1;
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(bit en, bit frz, bit [1:0] ck, bit [2:0] md, bit sp, bit sd, bit sh);
    @(negedge clk);
    cfg_we = 1'b1; cfg_en = en; cfg_frz = frz; cfg_clk = ck; cfg_mode = md;
    cfg_src_per = sp; cfg_src_duty = sd; cfg_src_ph = sh;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Period in clocks, high clocks and update pulses between two eoc pulses.
  task automatic measure(output int per, output int hi, output int up);
    int guard;
    per = 0; hi = 0; up = 0; guard = 0;
    while (!eoc_o && guard < 400) begin @(negedge clk); guard++; end
    if (!eoc_o) return;
    do begin
      per++;
      if (pwm_o) hi++;
      if (upd_o) up++;
      @(negedge clk);
    end while (!eoc_o && per < 400);
    if (!eoc_o) per = 0;
  endtask

  task automatic window(int n, output int e, output int h, output int u);
    e = 0; h = 0; u = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (eoc_o) e++;
      if (pwm_o) h++;
      if (upd_o) u++;
    end
  endtask

  typedef struct packed {
    logic [2:0] md;
    logic       sp, sd, sh;
    logic [1:0] ck;
    logic [7:0] per, hi, up;
  } vec_t;

  // local: P=9 D=3 PH=2 ; master: P=5 D=4 PH=0
  localparam vec_t VEC [9] = '{
    '{3'b000, 1'b0, 1'b0, 1'b0, 2'b01, 8'd10, 8'd3,  8'd1},
    '{3'b001, 1'b1, 1'b0, 1'b0, 2'b01, 8'd6,  8'd3,  8'd1},
    '{3'b010, 1'b0, 1'b1, 1'b1, 2'b01, 8'd10, 8'd4,  8'd1},
    '{3'b100, 1'b0, 1'b0, 1'b0, 2'b01, 8'd18, 8'd6,  8'd1},
    '{3'b101, 1'b0, 1'b0, 1'b0, 2'b01, 8'd18, 8'd6,  8'd2},
    '{3'b110, 1'b1, 1'b1, 1'b1, 2'b01, 8'd10, 8'd8,  8'd1},
    '{3'b111, 1'b0, 1'b1, 1'b0, 2'b01, 8'd18, 8'd8,  8'd2},
    '{3'b000, 1'b1, 1'b1, 1'b1, 2'b10, 8'd12, 8'd8,  8'd1},
    '{3'b100, 1'b0, 1'b0, 1'b0, 2'b11, 8'd54, 8'd18, 8'd1}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    int p, h, u, e;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_en = 1'b0; cfg_frz = 1'b0; cfg_clk = 2'b00;
    cfg_mode = 3'b000; cfg_src_per = 1'b0; cfg_src_duty = 1'b0; cfg_src_ph = 1'b0;
    loc_per = 9; loc_duty = 3; loc_ph = 2; mst_per = 5; mst_duty = 4; mst_ph = 0;
    dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset outputs", {29'd0, pwm_o, eoc_o, upd_o}, 0);
    rst_n = 1'b1;
    window(10, e, h, u);
    chk("R8 idle after reset", e + h + u, 0);

    // Table walk: modes, sources, tick selects.
    foreach (VEC[i]) begin
      wr(1'b0, 1'b0, cfg_clk, cfg_mode, 1'b0, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      wr(1'b1, 1'b0, VEC[i].ck, VEC[i].md, VEC[i].sp, VEC[i].sd, VEC[i].sh);
      measure(p, h, u);
      chk($sformatf("R1 R2 R3 R5 period vec %0d", i), p, int'(VEC[i].per));
      chk($sformatf("R1 R2 R3 R5 high vec %0d", i), h, int'(VEC[i].hi));
      chk($sformatf("R4 updates vec %0d", i), u, int'(VEC[i].up));
    end

    // R5: no tick source, counter never wraps.
    wr(1'b0, 1'b0, cfg_clk, cfg_mode, 1'b0, 1'b0, 1'b0);
    wr(1'b1, 1'b0, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0);
    window(60, e, h, u);
    chk("R5 no tick eoc count", e, 0);

    // R6: mode and tick writes refused while running.
    wr(1'b0, 1'b0, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0);
    wr(1'b1, 1'b0, 2'b01, 3'b000, 1'b0, 1'b0, 1'b0);
    measure(p, h, u);
    chk("R6 period before locked write", p, 10);
    wr(1'b1, 1'b0, 2'b00, 3'b100, 1'b0, 1'b0, 1'b0);
    measure(p, h, u);
    chk("R6 period after locked write", p, 10);
    chk("R6 high after locked write", h, 3);

    // R7: freeze with halt stops; halt alone does not.
    wr(1'b1, 1'b1, 2'b01, 3'b000, 1'b0, 1'b0, 1'b0);
    dbg_halt = 1'b1;
    window(60, e, h, u);
    chk("R7 frozen eoc count", e, 0);
    wr(1'b1, 1'b0, 2'b01, 3'b000, 1'b0, 1'b0, 1'b0);
    measure(p, h, u);
    chk("R7 halt ignored period", p, 10);
    dbg_halt = 1'b0;

    // R8: disable silences the channel.
    wr(1'b0, 1'b0, 2'b01, 3'b000, 1'b0, 1'b0, 1'b0);
    window(40, e, h, u);
    chk("R8 disabled activity", e + h + u, 0);

    // R9: reserved mode stays quiet.
    wr(1'b1, 1'b0, 2'b01, 3'b011, 1'b0, 1'b0, 1'b0);
    window(40, e, h, u);
    chk("R9 reserved activity", e + h + u, 0);

    finish_run();
  end

endmodule